// File: doc/BRIEF.md
# Packed 3-bit pixel serializer

This block turns a stream of bytes into a row of colour pixels on three output lines: one bit each for red, green and blue, so eight colours in all. Each incoming byte packs two neighbouring pixels. The first pixel of the pair sits in bits 2:0 and the second in bits 5:3. Bits 7:6 carry nothing and are dropped.

The block runs on a fast system clock. It holds every pixel for a fixed number of clock cycles, set by a parameter, so the output matches a slower pixel rate; the default of five cycles turns a 125 MHz clock into a 25 MHz pixel stream. While idle, the colour lines stay dark. A one-cycle line-start pulse from the timing logic begins a row of exactly 640 pixels, which is 320 byte pulls. When the row ends, the block goes dark and waits for the next pulse.

Bytes arrive on a valid/ready handshake, normally from a FIFO. If no byte is offered at the moment one is needed, that pixel pair is shown as black and a sticky underrun flag is raised.

Top module: `pixpair_serializer`

## Requirements
- R1: While no row is in progress, `rgb` is 0 and `byte_ready` stays low, even when `byte_valid` is high.
- R2: A `line_start` sampled high at a rising edge while idle starts a row. `byte_ready` is high in the next cycle, and the first pixel appears on `rgb` one edge after that.
- R3: Within a byte, the pixel in bits 2:0 is shown first and the pixel in bits 5:3 second.
- R4: Bits 7:6 of a byte have no effect on `rgb`.
- R5: Each pixel is held on `rgb` for exactly HOLD_CYCLES clock cycles (default 5), with no change inside that window.
- R6: A row has exactly ROW_PIXELS pixels (default 640) and makes exactly ROW_PIXELS/2 byte requests (cycles with `byte_ready` high). After the last pixel's window, `rgb` returns to 0 and no further requests are made.
- R7: A `line_start` pulse that arrives while a row is being shifted out has no effect. The row ends on schedule and no second row follows.
- R8: When `byte_ready` is high and `byte_valid` is low, no byte is taken, both pixels of that pair show as 0, and `underrun` goes high and stays high until reset. The following pairs take the bytes that are offered next.
- R9: An active-low `rst_n` forces `rgb` to 0 and `underrun` to 0, cancels any row in progress, and leaves the block idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | One-cycle pulse that begins a row |
| byte_valid | input | 1 | A byte is offered on `byte_data` |
| byte_data | input | BYTE_BITS | Two packed pixels: bits 2:0 first, bits 5:3 second |
| byte_ready | output | 1 | The block takes the offered byte at this edge |
| rgb | output | PIX_BITS | Colour bits of the current pixel |
| underrun | output | 1 | Sticky flag: a byte was needed and none was offered |

## Verification
The assertions assume that `line_start` is a one-cycle pulse, and that `byte_valid` and `byte_data` settle before the edge at which `byte_ready` is sampled. The bench drives every input on the falling clock edge, so both assumptions hold. Its FIFO model raises `byte_valid` only in response to `byte_ready`, except in the idle test, where it holds `byte_valid` high on purpose. Starvation is produced by withholding exactly one requested byte at a chosen pair index. The mid-row `line_start` is likewise a single clean pulse, so the checks on stall and restart behaviour never see an ill-formed handshake.

// File: rtl/pss_pkg.sv
package pss_pkg;

  // Row sequencer state.
  typedef enum logic {
    ROW_IDLE  = 1'b0,
    ROW_SHIFT = 1'b1
  } row_state_e;

  // Counter width for a count range of n values.
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/pss_pace.sv
// Pixel-period divider: marks the first and the last cycle of every pixel window.
module pss_pace #(
  parameter int unsigned HOLD_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic load_o,
  output logic wrap_o
);

  generate
    if (HOLD_CYC == 1) begin : g_nodiv
      // Every cycle is both the start and the end of a pixel window.
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst_n;
      assign load_o = run_i;
      assign wrap_o = run_i;
    end else begin : g_div
      localparam int unsigned HW = pss_pkg::cnt_w(HOLD_CYC);
      localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYC - 1);

      logic [HW-1:0] hold_q, hold_d;
      logic          hold_en;

      always_comb begin
        hold_en = run_i || (hold_q != '0);
        hold_d  = hold_q;
        if (!run_i || (hold_q == HOLD_LAST)) begin
          hold_d = '0;
        end else begin
          hold_d = hold_q + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          hold_q <= '0;
        end else if (hold_en) begin
          hold_q <= hold_d;
        end
      end

      assign load_o = run_i && (hold_q == '0);
      assign wrap_o = run_i && (hold_q == HOLD_LAST);

      // R5
      hold_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q <= HOLD_LAST);

      // R5
      hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (hold_q == '0));
    end
  endgenerate

endmodule

// File: rtl/pss_seq.sv
// Row sequencer: counts pixels of one row, starts on a line-start pulse.
module pss_seq #(
  parameter int unsigned ROW_PIX = 640
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_start_i,
  input  logic wrap_i,
  output logic active_o,
  output logic even_o,
  output logic row_end_o,
  output logic done_o
);
  import pss_pkg::*;

  localparam int unsigned PW = cnt_w(ROW_PIX);
  localparam logic [PW-1:0] PIX_LAST = PW'(ROW_PIX - 1);

  row_state_e    state_q, state_d;
  logic [PW-1:0] pix_q, pix_d;
  logic          done_q, done_d;
  logic          row_end;

  always_comb begin
    state_d = state_q;
    pix_d   = pix_q;
    row_end = (state_q == ROW_SHIFT) && wrap_i && (pix_q == PIX_LAST);
    case (state_q)
      ROW_IDLE: begin
        if (line_start_i) begin
          state_d = ROW_SHIFT;
          pix_d   = '0;
        end
      end
      ROW_SHIFT: begin
        // line_start_i is deliberately not looked at here.
        if (wrap_i) begin
          if (pix_q == PIX_LAST) begin
            state_d = ROW_IDLE;
            pix_d   = '0;
          end else begin
            pix_d = pix_q + 1'b1;
          end
        end
      end
      default: state_d = ROW_IDLE;
    endcase
    done_d = row_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ROW_IDLE;
      pix_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pix_q   <= pix_d;
      done_q  <= done_d;
    end
  end

  assign active_o  = (state_q == ROW_SHIFT);
  assign even_o    = (pix_q[0] == 1'b0);
  assign row_end_o = row_end;
  assign done_o    = done_q;

  // R7
  row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && !row_end_o) |=> active_o);

  // R6
  pix_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_q <= PIX_LAST);

  // R6
  row_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_end_o |=> (!active_o && done_o));

endmodule

// File: rtl/pss_unpack.sv
// Byte unpacker: takes a byte per pixel pair and presents its two pixels in turn.
module pss_unpack #(
  parameter int unsigned PIX_W  = 3,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              even_i,
  input  logic              done_i,
  input  logic              valid_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              ready_o,
  output logic [PIX_W-1:0]  rgb_o,
  output logic              underrun_o
);

  logic [PIX_W-1:0] rgb_q, rgb_d;
  logic [PIX_W-1:0] hi_q, hi_d;
  logic             und_q, und_d;
  logic [PIX_W-1:0] lo_pix, hi_pix;

  assign lo_pix = data_i[PIX_W-1:0];
  assign hi_pix = data_i[2*PIX_W-1:PIX_W];

  generate
    if (2 * PIX_W < BYTE_W) begin : g_pad
      // Spare top bits of a byte carry no pixel.
      logic unused_pad_bits;
      assign unused_pad_bits = ^data_i[BYTE_W-1:2*PIX_W];
    end
  endgenerate

  assign ready_o = load_i && even_i;

  always_comb begin
    rgb_d = rgb_q;
    hi_d  = hi_q;
    und_d = und_q;
    if (done_i) begin
      rgb_d = '0;
    end else if (load_i) begin
      if (even_i) begin
        if (valid_i) begin
          rgb_d = lo_pix;
          hi_d  = hi_pix;
        end else begin
          rgb_d = '0;
          hi_d  = '0;
          und_d = 1'b1;
        end
      end else begin
        rgb_d = hi_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rgb_q <= '0;
      hi_q  <= '0;
      und_q <= 1'b0;
    end else begin
      if (done_i || load_i) begin
        rgb_q <= rgb_d;
      end
      if (ready_o) begin
        hi_q <= hi_d;
      end
      und_q <= und_d;
    end
  end

  assign rgb_o      = rgb_q;
  assign underrun_o = und_q;

  // R3
  low_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && valid_i) |=> (rgb_o == $past(lo_pix)));

  // R8
  starve_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && !valid_i) |=> (underrun_o && (rgb_o == '0)));

  // R8
  starve_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_o |=> underrun_o);

endmodule

// File: rtl/pixpair_serializer.sv
// Packed 3-bit pixel serializer, top level.
module pixpair_serializer #(
  parameter int unsigned ROW_PIXELS  = 640,
  parameter int unsigned HOLD_CYCLES = 5,
  parameter int unsigned PIX_BITS    = 3,
  parameter int unsigned BYTE_BITS   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 line_start,
  input  logic                 byte_valid,
  input  logic [BYTE_BITS-1:0] byte_data,
  output logic                 byte_ready,
  output logic [PIX_BITS-1:0]  rgb,
  output logic                 underrun
);

  logic row_act;
  logic pix_load;
  logic pix_wrap;
  logic pix_even;
  logic row_end;
  logic row_done;

  pss_pace #(
    .HOLD_CYC (HOLD_CYCLES)
  ) u_pace (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (row_act),
    .load_o (pix_load),
    .wrap_o (pix_wrap)
  );

  pss_seq #(
    .ROW_PIX (ROW_PIXELS)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_start_i (line_start),
    .wrap_i       (pix_wrap),
    .active_o     (row_act),
    .even_o       (pix_even),
    .row_end_o    (row_end),
    .done_o       (row_done)
  );

  pss_unpack #(
    .PIX_W  (PIX_BITS),
    .BYTE_W (BYTE_BITS)
  ) u_unpack (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (pix_load),
    .even_i     (pix_even),
    .done_i     (row_done),
    .valid_i    (byte_valid),
    .data_i     (byte_data),
    .ready_o    (byte_ready),
    .rgb_o      (rgb),
    .underrun_o (underrun)
  );

  // R1
  idle_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !row_act |=> (rgb == '0));

  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (row_act && !pix_load) |=> $stable(rgb));

  // R6
  pull_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready |-> row_act);

  // R2
  start_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!row_act && line_start) |=> byte_ready);

  // R6
  row_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_end |=> !byte_ready);

endmodule

// File: tb/pixpair_serializer_test.sv
module pixpair_serializer_test;

  localparam int ROWP = 640;
  localparam int HOLD = 5;
  localparam int NV   = 5;

  // Vector table: byte base, byte step, starved pair (-1 none), underrun expected after the row.
  localparam logic [7:0] VB [NV] = '{8'h00, 8'hC5, 8'h3F, 8'hFF, 8'h92};
  localparam logic [7:0] VS [NV] = '{8'h01, 8'h07, 8'h0B, 8'h00, 8'h05};
  localparam int         VG [NV] = '{-1, -1, 100, -1, 319};
  localparam logic       VU [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1};

  logic       clk;
  logic       rst_n;
  logic       line_start;
  logic       byte_valid;
  logic [7:0] byte_data;
  logic       byte_ready;
  logic [2:0] rgb;
  logic       underrun;

  int  total = 0;
  int  bad   = 0;
  bit  fin   = 0;

  // FIFO model state.
  logic [7:0] f_base, f_step;
  int         f_gap  = -1;
  int         f_idx  = 0;
  int         f_req  = 0;
  bit         f_idle_valid = 0;

  pixpair_serializer uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_start (line_start),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .byte_ready (byte_ready),
    .rgb        (rgb),
    .underrun   (underrun)
  );

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Byte source: offers a byte only when asked, may withhold one request.
  initial begin
    byte_valid = 1'b0;
    byte_data  = 8'h00;
    forever begin
      @(negedge clk);
      if (byte_ready) begin
        if (f_req == f_gap) begin
          byte_valid = 1'b0;
        end else begin
          byte_valid = 1'b1;
          byte_data  = 8'(int'(f_base) + int'(f_step) * f_idx);
          f_idx++;
        end
        f_req++;
      end else begin
        byte_valid = f_idle_valid;
        byte_data  = f_idle_valid ? 8'h2D : 8'h00;
      end
    end
  end

  function automatic logic [2:0] exp_pix(input logic [7:0] base, input logic [7:0] step,
                                          input int gap, input int k);
    int p;
    int b;
    logic [7:0] bt;
    p = k / 2;
    if (gap >= 0 && p == gap) return 3'b000;
    b  = (gap >= 0 && p > gap) ? p - 1 : p;
    bt = 8'(int'(base) + int'(step) * b);
    return (k % 2 == 1) ? bt[5:3] : bt[2:0];
  endfunction

  task automatic run_row(input logic [7:0] base, input logic [7:0] step, input int gap,
                         input logic exp_und, input bit mid);
    int miss;
    logic [2:0] fa, fe;
    int fk;
    miss = 0; fa = '0; fe = '0; fk = 0;
    f_base = base; f_step = step; f_gap = gap; f_idx = 0; f_req = 0;
    @(negedge clk);
    line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    // R2: request is raised the cycle after the start edge
    check("R2 first request", {31'd0, byte_ready}, 32'd1);
    @(negedge clk);
    for (int k = 0; k < ROWP; k++) begin
      for (int w = 0; w < HOLD; w++) begin
        if (rgb !== exp_pix(base, step, gap, k)) begin
          if (miss == 0) begin fa = rgb; fe = exp_pix(base, step, gap, k); fk = k; end
          miss++;
        end
        if (mid && k == 300 && w == 0) line_start = 1'b1;
        if (w == 1) line_start = 1'b0;
        @(negedge clk);
      end
    end
    // R3 R4 R5: every cycle of every pixel matched the packed byte stream
    total++;
    if (miss != 0) begin
      bad++;
      $display("FAIL R3 R4 R5 pixel %0d actual=%0h expected=%0h (%0d mismatches)", fk, fa, fe, miss);
    end
    check("R6 dark after row", {29'd0, rgb}, 32'd0);
    check("R6 request count", f_req, ROWP / 2);
    check("R8 underrun after row", {31'd0, underrun}, {31'd0, exp_und});
    // R6 R7: no further requests, no second row
    miss = 0;
    for (int c = 0; c < 3 * HOLD; c++) begin
      if (byte_ready !== 1'b0 || rgb !== 3'b000) miss++;
      @(negedge clk);
    end
    check(mid ? "R7 no restart" : "R6 stays idle", miss, 0);
  endtask

  initial begin
    int miss;
    rst_n = 1'b0;
    line_start = 1'b0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 rgb in reset", {29'd0, rgb}, 32'd0);
    check("R9 underrun in reset", {31'd0, underrun}, 32'd0);
    check("R9 ready in reset", {31'd0, byte_ready}, 32'd0);
    rst_n = 1'b1;

    // R1: valid held high while idle takes nothing and shows nothing
    f_idle_valid = 1'b1;
    miss = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (byte_ready !== 1'b0 || rgb !== 3'b000) miss++;
    end
    check("R1 idle ignores valid", miss, 0);
    f_idle_valid = 1'b0;
    @(negedge clk);

    // Table walk.
    for (int v = 0; v < NV; v++) begin
      run_row(VB[v], VS[v], VG[v], VU[v], 1'b0);
    end

    // R9: reset in the middle of a row cancels it and clears the flag
    @(negedge clk);
    line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    repeat (60) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 rgb after mid-row reset", {29'd0, rgb}, 32'd0);
    check("R9 underrun cleared", {31'd0, underrun}, 32'd0);
    rst_n = 1'b1;
    miss = 0;
    for (int c = 0; c < 4 * HOLD; c++) begin
      @(negedge clk);
      if (byte_ready !== 1'b0 || rgb !== 3'b000) miss++;
    end
    check("R9 row cancelled", miss, 0);

    // R4: only the spare bits set gives a dark row
    run_row(8'hC0, 8'h00, -1, 1'b0, 1'b0);
    // R7: a start pulse in mid-row is ignored
    run_row(8'h1A, 8'h03, -1, 1'b0, 1'b1);

    fin = 1;
    summary();
    $finish;
  end

endmodule